// File: doc/BRIEF.md
# Run-Time Selectable ECC/Parity Protected Word RAM

This block holds a small single-port word memory together with a protection unit that guards every stored word. The same array can be protected in one of two ways, picked at run time by a mode bit. The first is a single-error-correcting, double-error-detecting Hamming code. The second is one even-parity bit per byte. On every normal write the unit computes fresh check bits and stores them next to the data word. On every read it checks the word and, in correcting mode, repairs a single flipped bit before returning it. Any detected fault raises a sticky error flag.

A small control register holds the mode bit, the protection enable and a trap-disable bit. It is read back together with the error flag. A separate clear strobe drops the flag, but only when the most recently accessed address is currently free of faults. Until that is true, software must first touch a clean location. A trap request follows the flag unless the trap-disable bit, which is set out of reset, masks it. For fault injection, a write can keep the previously stored check bits, so the new data no longer matches its code.

Check bits are undefined at power-up. Each location must therefore be written once before protection is turned on. Reads return data and status one clock after the request. Writes update data and check bits at the request edge.

Top module: `ram_prot`

## Requirements
- R1: The control register reads back on `cfg_rdata_o` as {flag, trap-disable, enable, mode} in bits 3..0. Writing `cfg_wdata_i` sets mode from bit 0 (0 = Hamming correction, 1 = byte parity), enable from bit 1 and trap-disable from bit 2. Reset gives mode 0, enable 0 and trap-disable 1.
- R2: In parity mode each byte has one even-parity bit, held in check bit 0 (low byte) and check bit 1 (high byte). An odd number of flipped bits in a byte sets the flag, and the stored word is returned uncorrected. Two flips within one byte are not detected.
- R3: In Hamming mode with protection enabled, a single flipped data bit is corrected in the returned word and sets the flag. Two flipped data bits set the flag, and the stored word is returned as is.
- R4: With protection disabled, reads return the raw stored word and never set the flag.
- R5: A normal write stores check bits computed from the written data, so later reads of that word show no fault. A write with `keep_chk_i` high replaces only the data and leaves the old check bits in place.
- R6: `rvalid_o` and `rdata_o` reflect a read exactly one clock after the request cycle, and the flag is set on that same edge. `rvalid_o` is low after any cycle without a read.
- R7: Once set, the flag stays set until a clear takes effect.
- R8: A clear strobe is ignored while the last accessed address holds a fault under the current mode and enable. After an access to a fault-free address, the clear drops the flag on the next edge.
- R9: `trap_req_o` is high exactly when the flag is set and trap-disable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Memory access request |
| we_i | input | 1 | 1 = write, 0 = read |
| keep_chk_i | input | 1 | On write: keep old check bits (fault injection) |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one clock after request |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 3 | {trap-disable, enable, mode} |
| cfg_rdata_o | output | 4 | {flag, trap-disable, enable, mode} |
| err_clr_i | input | 1 | Error flag clear strobe |
| err_flag_o | output | 1 | Sticky error flag |
| trap_req_o | output | 1 | Trap request, masked by trap-disable |

## Verification
The bench injects faults with check-preserving writes. It then confirms three things: that a single data flip comes back repaired, that a double flip comes back raw but flagged, and that two flips in the same byte slip past parity. A design that corrected in parity mode, or that flagged while disabled, would return the wrong word or raise the flag. Clearing is tried twice: first while the last address still holds a fault, which a naive clear would wrongly honour, and then after reading a clean word. A normal rewrite of a faulty location is checked to leave it clean. The trap output is compared against the flag and the trap-disable bit on every clock.

// File: rtl/ram_prot_pkg.sv
package ram_prot_pkg;

   // smallest r with 2**r >= data bits + r + 1
   function automatic int ham_bits(input int dw);
      int r;
      r = 1;
      while ((1 << r) < dw + r + 1) r++;
      return r;
   endfunction

   typedef struct packed {
      logic trap_dis;
      logic prot_en;
      logic par_sel;
   } prot_cfg_t;

endpackage

// File: rtl/prot_encode.sv
module prot_encode #(
   parameter int DATA_W = 16,
   parameter int CHK_W  = 6
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic              par_sel_i,
   output logic [CHK_W-1:0]  chk_o
);
   localparam int HAM_W = ram_prot_pkg::ham_bits(DATA_W);
   localparam int CW    = DATA_W + HAM_W;
   localparam int NBYTE = DATA_W / 8;

   logic [HAM_W-1:0] ham;
   logic [NBYTE-1:0] par;

   always_comb begin
      int k;
      ham = '0;
      k   = 0;
      for (int p = 1; p <= CW; p++) begin
         if ((p & (p - 1)) != 0) begin
            for (int i = 0; i < HAM_W; i++)
               if (p[i]) ham[i] = ham[i] ^ data_i[k];
            k++;
         end
      end
   end

   for (genvar b = 0; b < NBYTE; b++) begin : g_byte
      assign par[b] = ^data_i[8*b +: 8];
   end

   if (CHK_W > NBYTE) begin : g_pad
      assign chk_o = par_sel_i ? {{(CHK_W-NBYTE){1'b0}}, par} : {^{data_i, ham}, ham};
   end else begin : g_nopad
      assign chk_o = par_sel_i ? par : {^{data_i, ham}, ham};
   end
endmodule

// File: rtl/prot_check.sv
module prot_check #(
   parameter int DATA_W = 16,
   parameter int CHK_W  = 6
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [CHK_W-1:0]  chk_i,
   input  logic              par_sel_i,
   input  logic              en_i,
   output logic              err_o,
   output logic [DATA_W-1:0] data_o
);
   localparam int HAM_W = ram_prot_pkg::ham_bits(DATA_W);
   localparam int CW    = DATA_W + HAM_W;
   localparam int NBYTE = DATA_W / 8;

   logic [HAM_W-1:0]  syn;
   logic              ov_odd;
   logic [NBYTE-1:0]  mism;
   logic [DATA_W-1:0] fixed;

   always_comb begin
      int k;
      syn = chk_i[HAM_W-1:0];
      k   = 0;
      for (int p = 1; p <= CW; p++) begin
         if ((p & (p - 1)) != 0) begin
            for (int i = 0; i < HAM_W; i++)
               if (p[i]) syn[i] = syn[i] ^ data_i[k];
            k++;
         end
      end
   end

   assign ov_odd = ^{data_i, chk_i[HAM_W:0]};

   // flip the data bit the syndrome points at
   always_comb begin
      int k;
      fixed = data_i;
      k     = 0;
      for (int p = 1; p <= CW; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (int'(syn) == p) fixed[k] = ~data_i[k];
            k++;
         end
      end
   end

   for (genvar b = 0; b < NBYTE; b++) begin : g_byte
      assign mism[b] = chk_i[b] ^ (^data_i[8*b +: 8]);
   end

   always_comb begin
      if (!en_i) begin
         err_o  = 1'b0;
         data_o = data_i;
      end else if (par_sel_i) begin
         err_o  = |mism;
         data_o = data_i;
      end else begin
         err_o  = (syn != '0) || ov_odd;
         data_o = (ov_odd && syn != '0) ? fixed : data_i;
      end
   end
endmodule

// File: rtl/prot_status.sv
module prot_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic sel_bad_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 flag_o <= 1'b0;
      else if (set_i)             flag_o <= 1'b1;
      else if (clr_i && !sel_bad_i) flag_o <= 1'b0;
   end
endmodule

// File: rtl/ram_prot.sv
module ram_prot #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 16,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              we_i,
   input  logic              keep_chk_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rvalid_o,
   input  logic              cfg_we_i,
   input  logic [2:0]        cfg_wdata_i,
   output logic [3:0]        cfg_rdata_o,
   input  logic              err_clr_i,
   output logic              err_flag_o,
   output logic              trap_req_o
);
   import ram_prot_pkg::*;

   localparam int HAM_W = ham_bits(DATA_W);
   localparam int CHK_W = HAM_W + 1;
   localparam int NBYTE = DATA_W / 8;

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of bytes");
   end
   if (NBYTE > CHK_W) begin : g_bad_par
      $error("check storage too narrow for byte parity");
   end
   if (DEPTH < 2 || (1 << ADDR_W) < DEPTH) begin : g_bad_depth
      $error("DEPTH/ADDR_W mismatch");
   end

   logic [DATA_W-1:0] mem_d [DEPTH];
   logic [CHK_W-1:0]  mem_c [DEPTH];

   prot_cfg_t         cfg_q;
   logic [ADDR_W-1:0] sel_q;
   logic [CHK_W-1:0]  wr_chk;
   logic              rd_err, sel_err;
   logic [DATA_W-1:0] rd_fix, sel_fix;
   logic              rd_go;

   assign rd_go = req_i && !we_i;

   prot_encode #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
      .data_i    (wdata_i),
      .par_sel_i (cfg_q.par_sel),
      .chk_o     (wr_chk)
   );

   prot_check #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_rd_chk (
      .data_i    (mem_d[addr_i]),
      .chk_i     (mem_c[addr_i]),
      .par_sel_i (cfg_q.par_sel),
      .en_i      (cfg_q.prot_en),
      .err_o     (rd_err),
      .data_o    (rd_fix)
   );

   // watches the last accessed word to qualify a clear
   prot_check #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_sel_chk (
      .data_i    (mem_d[sel_q]),
      .chk_i     (mem_c[sel_q]),
      .par_sel_i (cfg_q.par_sel),
      .en_i      (cfg_q.prot_en),
      .err_o     (sel_err),
      .data_o    (sel_fix)
   );

   prot_status u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (rd_go && rd_err),
      .clr_i     (err_clr_i),
      .sel_bad_i (sel_err),
      .flag_o    (err_flag_o)
   );

   // storage: no reset, contents undefined until written
   always_ff @(posedge clk) begin
      if (req_i && we_i) begin
         mem_d[addr_i] <= wdata_i;
         if (!keep_chk_i) mem_c[addr_i] <= wr_chk;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= '{trap_dis: 1'b1, prot_en: 1'b0, par_sel: 1'b0};
         sel_q    <= '0;
         rvalid_o <= 1'b0;
         rdata_o  <= '0;
      end else begin
         if (cfg_we_i) cfg_q <= prot_cfg_t'(cfg_wdata_i);
         if (req_i)    sel_q <= addr_i;
         rvalid_o <= rd_go;
         if (rd_go)    rdata_o <= rd_fix;
      end
   end

   assign cfg_rdata_o = {err_flag_o, cfg_q.trap_dis, cfg_q.prot_en, cfg_q.par_sel};
   assign trap_req_o  = err_flag_o && !cfg_q.trap_dis;

   logic unused_sel;
   assign unused_sel = ^sel_fix;
endmodule

// File: rtl/ram_prot_chk.sv
module ram_prot_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_i,
   input logic       we_i,
   input logic       rvalid_o,
   input logic       err_flag_o,
   input logic       err_clr_i,
   input logic       trap_req_o,
   input logic [3:0] cfg_rdata_o
);
   a_r6_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !we_i) |=> rvalid_o);

   a_r6_rvalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_i && !we_i) |=> !rvalid_o);

   a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag_o && !err_clr_i) |=> err_flag_o);

   a_r8_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_flag_o) |-> $past(err_clr_i));

   a_r4_no_set_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_flag_o && !cfg_rdata_o[1]) |=> !err_flag_o);

   a_r9_trap_masked: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata_o[2] |-> !trap_req_o);
endmodule

bind ram_prot ram_prot_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_i       (req_i),
   .we_i        (we_i),
   .rvalid_o    (rvalid_o),
   .err_flag_o  (err_flag_o),
   .err_clr_i   (err_clr_i),
   .trap_req_o  (trap_req_o),
   .cfg_rdata_o (cfg_rdata_o)
);

// File: tb/ram_prot_tb.sv
`timescale 1ns/100ps
module ram_prot_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, we = 1'b0, keep = 1'b0;
   logic [3:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        rvalid;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_wd = '0;
   logic [3:0]  cfg_rd;
   logic        clr = 1'b0;
   logic        flag, trap;

   int total = 0, fails = 0;
   bit started = 0, done = 0;

   // behavioural model
   logic [15:0] golden [16];
   logic [15:0] stored [16];
   bit m_flag = 0, m_en = 0, m_par = 0, m_tdis = 1;
   int m_sel = 0;

   always #2.5 clk = ~clk;

   ram_prot u_dut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .keep_chk_i(keep),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
      .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .cfg_rdata_o(cfg_rd),
      .err_clr_i(clr), .err_flag_o(flag), .trap_req_o(trap)
   );

   task automatic check(input bit ok, input string req_tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req_tag, what, act, exp);
      end
   endtask

   function automatic void expect_rd(input int a, output logic [15:0] d, output bit e);
      logic [15:0] diff;
      diff = stored[a] ^ golden[a];
      d = stored[a];
      e = 0;
      if (!m_en) return;
      if (m_par) begin
         e = ($countones(diff[7:0]) % 2 == 1) || ($countones(diff[15:8]) % 2 == 1);
      end else begin
         if ($countones(diff) == 1) begin d = golden[a]; e = 1; end
         else if ($countones(diff) >= 2) e = 1;
      end
   endfunction

   // every-clock comparison of flag and trap against the model
   always @(negedge clk) begin
      if (started && !done) begin
         check(flag == m_flag, "R7", "flag vs model", 32'(flag), 32'(m_flag));
         check(trap == (m_flag && !m_tdis), "R9", "trap vs model", 32'(trap),
               32'(m_flag && !m_tdis));
      end
   end

   task automatic wr(input int a, input logic [15:0] d, input bit k);
      @(negedge clk);
      req = 1; we = 1; keep = k; addr = 4'(a); wdata = d;
      @(posedge clk); #1;
      stored[a] = d;
      if (!k) golden[a] = d;
      m_sel = a;
      @(negedge clk);
      req = 0; we = 0; keep = 0;
   endtask

   task automatic rd(input int a, input string tag);
      logic [15:0] ed; bit ee;
      @(negedge clk);
      expect_rd(a, ed, ee);
      req = 1; we = 0; addr = 4'(a);
      @(posedge clk); #1;
      if (ee) m_flag = 1;
      m_sel = a;
      @(negedge clk);
      req = 0;
      check(rvalid == 1'b1, "R6", "rvalid one clock after read", 32'(rvalid), 32'd1);
      check(rdata == ed, tag, "read data", 32'(rdata), 32'(ed));
   endtask

   task automatic cfg(input bit par, input bit en, input bit tdis);
      @(negedge clk);
      cfg_we = 1; cfg_wd = {tdis, en, par};
      @(posedge clk); #1;
      m_par = par; m_en = en; m_tdis = tdis;
      @(negedge clk);
      cfg_we = 0;
      check(cfg_rd[2:0] == {tdis, en, par}, "R1", "control readback",
            32'(cfg_rd[2:0]), 32'({tdis, en, par}));
      check(rvalid == 1'b0, "R6", "rvalid low after non-read", 32'(rvalid), 32'd0);
   endtask

   task automatic clear(input string tag);
      logic [15:0] dd; bit bad;
      @(negedge clk);
      expect_rd(m_sel, dd, bad);
      clr = 1;
      @(posedge clk); #1;
      if (!bad) m_flag = 0;
      @(negedge clk);
      clr = 0;
      check(cfg_rd[3] == m_flag, tag, "flag after clear", 32'(cfg_rd[3]), 32'(m_flag));
   endtask

   task automatic rewrite_all;
      for (int i = 0; i < 16; i++) wr(i, 16'h1357 * 16'(i + 1) ^ 16'hA5C3, 0);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1;
         total++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(cfg_rd == 4'b0100, "R1", "reset control value", 32'(cfg_rd), 32'h4);
      check(flag == 0 && trap == 0 && rvalid == 0, "R1", "reset outputs",
            32'({flag, trap, rvalid}), 32'd0);
      rst_n = 1;
      started = 1;

      // R5: write every word before enabling protection
      rewrite_all();
      cfg(0, 1, 1);
      rd(2, "R5");
      rd(9, "R5");

      // R3: single flip corrected, flagged; trap masked (R9)
      wr(3, golden[3] ^ 16'h0100, 1);
      rd(3, "R3");
      check(flag == 1 && trap == 0, "R9", "flag set, trap masked", 32'({flag, trap}), 32'h2);

      // R8: clear refused while last address is faulty
      clear("R8");
      rd(4, "R5");
      clear("R8");

      // R3: double flip returned raw and flagged
      wr(5, golden[5] ^ 16'h8001, 1);
      rd(5, "R3");
      rd(6, "R5");
      clear("R8");

      // R4: protection off, faulty word raw and unflagged
      cfg(0, 0, 1);
      rd(3, "R4");
      rd(5, "R4");
      check(flag == 0, "R4", "no flag while disabled", 32'(flag), 32'd0);

      // R9: trap enabled
      cfg(0, 1, 0);
      rd(3, "R9");
      check(trap == 1, "R9", "trap raised", 32'(trap), 32'd1);
      // R5: normal rewrite of faulty location cleans it, clear works in place
      wr(3, 16'h2468, 0);
      clear("R5");
      rd(3, "R5");

      // R2: parity mode
      cfg(1, 0, 0);
      rewrite_all();
      cfg(1, 1, 0);
      rd(7, "R2");
      wr(7, golden[7] ^ 16'h0010, 1);
      rd(7, "R2");
      rd(8, "R2");
      clear("R8");
      wr(10, golden[10] ^ 16'h0300, 1);
      rd(10, "R2");
      check(flag == 0, "R2", "same-byte double flip unseen", 32'(flag), 32'd0);
      wr(11, golden[11] ^ 16'h0180, 1);
      rd(11, "R2");
      check(flag == 1, "R2", "flips in both bytes seen", 32'(flag), 32'd1);
      clear("R8");
      rd(12, "R2");
      clear("R8");

      repeat (2) @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule